// File: doc/BRIEF.md
# Alternating-Direction Turntable Controller

This block steers a turntable gearbox from a single run request. The gearbox takes two control bits: a spin bit that makes it rotate when high and stop when low, and a direction bit that selects clockwise (high) or counterclockwise (low) while spinning. The heating controller raises the run request for as long as the turntable should turn.

Each new run turns the table the opposite way from the run before. The direction of the last run is kept while the table is idle, so the next run can reverse it. The block is a four-state synchronous machine, and its state bits are the two outputs, spin first and direction second. Both outputs come straight from flip-flops, and the run request reaches them with one cycle of latency.

After reset the machine is idle and remembers a counterclockwise run, so the first run after reset turns clockwise.

Top module: `turntable_ctrl`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `spinOut` and `cwOut` are 0 after that edge. This holds whatever `runReq` is and whether the table was spinning.
- R2: The first time `runReq` is sampled high after reset is released, the next edge gives `spinOut`=1 with `cwOut`=1 (clockwise).
- R3: While spinning, if `runReq` is sampled high, the next edge keeps `spinOut`=1 and leaves `cwOut` unchanged.
- R4: While spinning, if `runReq` is sampled low, the next edge gives `spinOut`=0 and leaves `cwOut` unchanged. `cwOut` keeps the direction of the run that just ended.
- R5: While idle, if `runReq` is sampled low, the next edge leaves both outputs unchanged.
- R6: While idle, if `runReq` is sampled high, the next edge gives `spinOut`=1 and inverts `cwOut`. This also applies when the request lasts only one cycle.
- R7: Out of reset, `spinOut` after every edge equals `runReq` as sampled at that edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| runReq | input | 1 | Run request from the heating controller; high means the table must turn |
| spinOut | output | 1 | Gearbox rotate bit, registered |
| cwOut | output | 1 | Gearbox direction bit, 1 clockwise and 0 counterclockwise, registered |

## Verification
The bench goes after the following corner cases, each with the wrong behaviour it would catch:
- **Direction after reset.** A design that leaves reset in the wrong idle state would start the first run counterclockwise.
- **Single-cycle request.** A design that only flips direction after a run of some length would repeat the same direction after a one-cycle pulse.
- **Stopping.** A design that clears or flips the direction bit when it stops would break the alternation of the next run.
- **Reset in mid-run.** A machine whose reset is not synchronous and dominant would keep spinning.
- **Long runs and long idle stretches.** A design that toggles direction on the level of the request, not on its rising edge, would flip the direction while running or while idle.

// File: rtl/turntable_pkg.sv
package turntable_pkg;

  // State encoding equals the output pair {spin, clockwise}.
  typedef enum logic [1:0] {
    PARK_AFTER_CCW = 2'b00,
    PARK_AFTER_CW  = 2'b01,
    SPIN_CCW       = 2'b10,
    SPIN_CW        = 2'b11
  } ttState_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic launch;  // idle -> spinning, reverse direction
    logic halt;    // spinning -> idle, keep direction
  } ttStrobe_t;

  localparam ttState_e TT_RESET_STATE = PARK_AFTER_CCW;
  localparam int TT_SPIN_BIT = 1;
  localparam int TT_DIR_BIT  = 0;

endpackage

// File: rtl/tt_control.sv
module tt_control
  import turntable_pkg::*;
(
  input  logic      runReq,
  input  logic      spinning,
  output ttStrobe_t strobe
);

  always_comb begin
    strobe        = '0;
    strobe.launch = runReq & ~spinning;
    strobe.halt   = ~runReq & spinning;
  end

endmodule

// File: rtl/tt_datapath.sv
module tt_datapath
  import turntable_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  ttStrobe_t strobe,
  output logic      spinOut,
  output logic      cwOut
);

  ttState_e curState;
  ttState_e nextState;

  always_comb begin
    nextState = curState;
    if (strobe.launch) begin
      nextState = ttState_e'({1'b1, ~curState[TT_DIR_BIT]});
    end else if (strobe.halt) begin
      nextState = ttState_e'({1'b0, curState[TT_DIR_BIT]});
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      curState <= TT_RESET_STATE;
    end else begin
      curState <= nextState;
    end
  end

  assign spinOut = curState[TT_SPIN_BIT];
  assign cwOut   = curState[TT_DIR_BIT];

endmodule

// File: rtl/turntable_ctrl.sv
module turntable_ctrl
  import turntable_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic runReq,
  output logic spinOut,
  output logic cwOut
);

  ttStrobe_t strobe;

  tt_control u_control (
    .runReq   (runReq),
    .spinning (spinOut),
    .strobe   (strobe)
  );

  tt_datapath u_datapath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .spinOut (spinOut),
    .cwOut   (cwOut)
  );

endmodule

// File: rtl/turntable_ctrl_checker.sv
module turntable_ctrl_checker (
  input logic clk,
  input logic rst,
  input logic runReq,
  input logic spinOut,
  input logic cwOut
);

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!spinOut && !cwOut));

  p_first_cw_r2: assert property (@(posedge clk) disable iff (rst)
    ($past(rst) && runReq) |=> (spinOut && cwOut));

  p_hold_run_r3: assert property (@(posedge clk) disable iff (rst)
    (spinOut && runReq) |=> (spinOut && $stable(cwOut)));

  p_stop_keep_r4: assert property (@(posedge clk) disable iff (rst)
    (spinOut && !runReq) |=> (!spinOut && $stable(cwOut)));

  p_idle_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!spinOut && !runReq) |=> ($stable(spinOut) && $stable(cwOut)));

  p_start_flip_r6: assert property (@(posedge clk) disable iff (rst)
    (!spinOut && runReq) |=> (spinOut && (cwOut != $past(cwOut))));

  p_spin_follows_r7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (spinOut == $past(runReq)));

endmodule

bind turntable_ctrl turntable_ctrl_checker u_chk (
  .clk     (clk),
  .rst     (rst),
  .runReq  (runReq),
  .spinOut (spinOut),
  .cwOut   (cwOut)
);

// File: tb/turntable_ctrl_bench.sv
module turntable_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int RANDOM_STEPS = 400;
  localparam int WATCHDOG_CYCLES = 200000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic runReq = 1'b0;
  logic spinOut;
  logic cwOut;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // bench model of the outputs
  logic modelSpin = 1'b0;
  logic modelCw = 1'b0;
  bit   freshReset = 1'b1;

  always #(CLK_PERIOD / 2) clk = ~clk;

  turntable_ctrl u_turntable_ctrl (
    .clk     (clk),
    .rst     (rst),
    .runReq  (runReq),
    .spinOut (spinOut),
    .cwOut   (cwOut)
  );

  function automatic logic [1:0] predict(input logic r, input logic spin,
                                         input logic cw, input logic req);
    if (r) return 2'b00;
    if (!spin && req) return {1'b1, ~cw};
    if (spin && !req) return {1'b0, cw};
    return {spin, cw};
  endfunction

  function automatic string reqTag(input logic r, input logic spin,
                                   input logic req, input bit fresh);
    if (r) return "R1";
    if (!spin && req) return fresh ? "R2/R6" : "R6";
    if (spin && req) return "R3/R7";
    if (spin && !req) return "R4/R7";
    return "R5";
  endfunction

  task automatic step(input logic rv, input logic req);
    logic [1:0] exp;
    string tag;
    rst = rv;
    runReq = req;
    tag = reqTag(rv, modelSpin, req, freshReset);
    exp = predict(rv, modelSpin, modelCw, req);
    @(posedge clk);
    if (rv) freshReset = 1'b1;
    else if (req && !modelSpin) freshReset = 1'b0;
    modelSpin = exp[1];
    modelCw = exp[0];
    @(negedge clk);
    compared++;
    if ({spinOut, cwOut} !== exp) begin
      mismatched++;
      $display("FAIL %s: spin/cw actual %b%b expected %b%b at %0t",
               tag, spinOut, cwOut, exp[1], exp[0], $time);
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG_CYCLES);
    if (!finished) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    @(negedge clk);
    // R1: reset state, even with request high
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    // R5: idle with no request
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    // R2: first run clockwise, R3 hold
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    step(1'b0, 1'b1);
    // R4: stop keeps clockwise
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    // R6: single-cycle pulse reverses to counterclockwise
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    // R6: next pulse back to clockwise
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    // R1: reset while spinning
    step(1'b0, 1'b1);
    step(1'b1, 1'b1);
    // R2: after reset, clockwise again
    step(1'b0, 1'b1);
    step(1'b0, 1'b0);
    // random mix of run lengths and rare resets
    for (int k = 0; k < RANDOM_STEPS; k++) begin
      logic nextReq;
      logic nextRst;
      nextReq = (($urandom % 4) == 0) ? ~runReq : runReq;
      nextRst = (($urandom % 64) == 0);
      step(nextRst, nextReq);
    end
    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule